// File: doc/BRIEF.md
# Interrupt CPU interface with nested priority tracking

This block is the per-processor side of an interrupt controller. A distributor in front of it offers the most urgent pending source as an ID and a 4-bit priority, where 0 is the most urgent. The block raises the processor's interrupt request when that source may preempt whatever is running. Software reaches it through a 32-bit word-addressed register port.

Reading the acknowledge register takes the offered source. The read returns its ID, pulses `ack_valid` with that ID so the distributor can mark the source active, and pushes its priority onto an internal stack of active priorities. Writing that same ID to the end-of-interrupt register pops the stack and restores the previous running priority. It also pulses `eoi_valid` so the distributor can retire the source. A read that finds nothing eligible returns the spurious ID 1023 and has no other effect. Register word indices are: 0 control, 1 priority mask, 2 acknowledge, 3 end of interrupt, 4 running priority. Reads of any other index return 0. Read data appears on `reg_rdata` in the cycle after `reg_rd`.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset, `irq` is 0, the control register reads 0, the mask register reads 0, and the running priority register reads 0xF0.
- R2: `irq` is 1 exactly when all of these hold: control bit 0 is set, `pend_valid` is 1, `pend_prio` is strictly below the mask level, `pend_prio` is strictly below the running priority, and the active stack is not full.
- R3: While control bit 0 is 0, `irq` is 0 and an acknowledge read returns 1023.
- R4: The mask register stores write bits [7:4] as the mask level and reads back with every other bit 0.
- R5: When a source qualifies as in R2, an acknowledge read returns its ID in bits [9:0] and pulses `ack_valid` for one cycle with `ack_id` equal to that ID. It also makes that source's priority the running priority.
- R6: An acknowledge read when nothing qualifies returns 1023, leaves `ack_valid` at 0 and leaves the running priority unchanged.
- R7: The running priority register reads the active stack's top priority in bits [7:4]. With nothing active it reads 0xF0.
- R8: A write to the end-of-interrupt register whose bits [9:0] equal the top active ID pops the stack. It pulses `eoi_valid` with that ID and restores the previous running priority.
- R9: An end-of-interrupt write whose ID differs from the top active ID, or that arrives with nothing active, is ignored: there is no `eoi_valid` pulse and the running priority is unchanged.
- R10: While a source is active, a pending source raises `irq` only if its priority is strictly more urgent than the active one.
- R11: When the stack holds DEPTH entries, `irq` stays 0 and an acknowledge read returns 1023 with no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pend_valid | input | 1 | Distributor offers a pending source |
| pend_id | input | 10 | ID of the offered source |
| pend_prio | input | 4 | Priority of the offered source, 0 most urgent |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request to the processor |
| ack_valid | output | 1 | One-cycle pulse: a source was acknowledged |
| ack_id | output | 10 | ID of the acknowledged source |
| eoi_valid | output | 1 | One-cycle pulse: a source was retired |
| eoi_id | output | 10 | ID of the retired source |

## Verification
The hardest state to reach is a full active stack with a still more urgent source pending. Strict preemption means each nesting level needs a more urgent priority than the one before. The bench therefore builds the block with a depth of two and acknowledges priorities 3 and then 1. It then offers priority 0, which must neither raise `irq` nor be taken. Mismatched end-of-interrupt writes are issued while two levels are active, so a wrong pop would show in the running priority that is read back.

// File: rtl/irq_cpu_if.sv
module irq_cpu_if #(
  parameter int DEPTH = 16,
  parameter int IDW   = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pend_valid,
  input  logic [IDW-1:0] pend_id,
  input  logic [3:0]     pend_prio,
  input  logic           reg_rd,
  input  logic           reg_wr,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq,
  output logic           ack_valid,
  output logic [IDW-1:0] ack_id,
  output logic           eoi_valid,
  output logic [IDW-1:0] eoi_id
);
  localparam int SW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDW-1:0] SPURIOUS = IDW'(1023);
  localparam logic [2:0] A_CTRL = 3'd0, A_MASK = 3'd1, A_ACK = 3'd2,
                         A_EOI = 3'd3, A_RUN = 3'd4;

  logic           en;
  logic [3:0]     mask;
  logic [SW-1:0]  sp;
  logic [IDW-1:0] stk_id [DEPTH];
  logic [3:0]     stk_pr [DEPTH];

  logic [IW-1:0]  top;
  logic           busy, full, elig, ack_go, eoi_go;
  logic [3:0]     run;

  assign busy   = sp != '0;
  assign full   = sp == SW'(DEPTH);
  assign top    = IW'(sp - SW'(1));
  assign run    = busy ? stk_pr[top] : 4'hF;
  assign elig   = en && pend_valid && !full && (pend_prio < mask) && (pend_prio < run);
  assign irq    = elig;
  assign ack_go = reg_rd && reg_addr == A_ACK && elig;
  assign eoi_go = reg_wr && reg_addr == A_EOI && busy && !ack_go &&
                  reg_wdata[IDW-1:0] == stk_id[top];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
      mask <= 4'h0;
      sp <= '0;
      ack_valid <= 1'b0;
      ack_id <= '0;
      eoi_valid <= 1'b0;
      eoi_id <= '0;
      reg_rdata <= '0;
    end else begin
      ack_valid <= ack_go;
      eoi_valid <= eoi_go;
      if (ack_go) begin
        ack_id <= pend_id;
        sp <= sp + SW'(1);
      end else if (eoi_go) begin
        eoi_id <= stk_id[top];
        sp <= sp - SW'(1);
      end
      if (reg_wr && reg_addr == A_CTRL) en <= reg_wdata[0];
      if (reg_wr && reg_addr == A_MASK) mask <= reg_wdata[7:4];
      if (reg_rd) begin
        case (reg_addr)
          A_CTRL:  reg_rdata <= {31'd0, en};
          A_MASK:  reg_rdata <= {24'd0, mask, 4'd0};
          A_ACK:   reg_rdata <= {{(32-IDW){1'b0}}, ack_go ? pend_id : SPURIOUS};
          A_RUN:   reg_rdata <= {24'd0, run, 4'd0};
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stk_id[i] <= '0;
        stk_pr[i] <= 4'hF;
      end else if (ack_go && sp == SW'(i)) begin
        stk_id[i] <= pend_id;
        stk_pr[i] <= pend_prio;
      end
    end
  end

  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SW'(DEPTH));

  // R5
  ack_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(reg_rd) && $past(reg_addr) == A_ACK);

  // R6
  spurious_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_rd) && $past(reg_addr) == A_ACK && reg_rdata[IDW-1:0] == SPURIOUS
      |-> sp == $past(sp) && !ack_valid);

  // R5
  ack_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> run == $past(pend_prio) && sp == $past(sp) + SW'(1));

  // R8
  eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> sp + SW'(1) == $past(sp) && $past(reg_wr));
endmodule

// File: tb/sim_irq_cpu_if.sv
module sim_irq_cpu_if;
  logic clk = 0, rst_n = 0;
  logic pend_valid = 0, reg_rd = 0, reg_wr = 0;
  logic [9:0] pend_id = 0;
  logic [3:0] pend_prio = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, ack_valid, eoi_valid;
  logic [9:0] ack_id, eoi_id;
  int total = 0, bad = 0;
  logic [31:0] exp_q [$];
  string tag_q [$];
  logic due = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  irq_cpu_if #(.DEPTH(2)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic offer(input logic v, input logic [9:0] id, input logic [3:0] p);
    @(negedge clk);
    pend_valid = v; pend_id = id; pend_prio = p;
    #1;
  endtask

  always @(posedge clk) due <= reg_rd;
  always @(negedge clk) if (due && exp_q.size() > 0) begin
    automatic logic [31:0] e = exp_q.pop_front();
    automatic string t = tag_q.pop_front();
    chk(t, reg_rdata, e);
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 irq", irq, 0);
    rd(0, 0, "R1 ctrl"); rd(1, 0, "R1 mask"); rd(4, 32'hF0, "R1 run");
    offer(1, 5, 3);
    chk("R3 irq disabled", irq, 0);
    wr(0, 1);
    chk("R2 mask zero blocks", irq, 0);
    wr(1, 32'hF0);
    chk("R2 irq up", irq, 1);
    wr(0, 0);
    chk("R3 irq gated", irq, 0);
    rd(2, 1023, "R3 ack disabled");
    rd(4, 32'hF0, "R6 run unchanged");
    wr(0, 1);
    wr(1, 32'hFFFF_FF3F);
    rd(1, 32'h30, "R4 mask readback");
    chk("R2 equal prio blocked", irq, 0);
    wr(1, 32'hF0);
    rd(2, 5, "R5 ack id");
    chk("R5 ack_valid", ack_valid, 1);
    chk("R5 ack_id", ack_id, 5);
    rd(4, 32'h30, "R7 run top");
    chk("R10 same prio no preempt", irq, 0);
    offer(1, 9, 1);
    chk("R10 urgent preempts", irq, 1);
    offer(1, 9, 4);
    chk("R10 less urgent held", irq, 0);
    offer(1, 9, 1);
    rd(2, 9, "R5 nested ack");
    rd(4, 32'h10, "R7 nested run");
    offer(1, 7, 0);
    chk("R11 full no irq", irq, 0);
    rd(2, 1023, "R11 full ack spurious");
    chk("R11 no ack_valid", ack_valid, 0);
    rd(4, 32'h10, "R11 run unchanged");
    wr(3, 5);
    chk("R9 no eoi pulse", eoi_valid, 0);
    rd(4, 32'h10, "R9 run unchanged");
    wr(3, 9);
    chk("R8 eoi pulse", eoi_valid, 1);
    chk("R8 eoi id", eoi_id, 9);
    rd(4, 32'h30, "R8 restored");
    wr(3, 5);
    rd(4, 32'hF0, "R8 idle");
    wr(3, 5);
    chk("R9 eoi idle ignored", eoi_valid, 0);
    offer(0, 3, 0);
    chk("R2 no valid no irq", irq, 0);
    rd(2, 1023, "R6 spurious");
    chk("R6 no ack_valid", ack_valid, 0);
    rd(4, 32'hF0, "R6 run idle");
    rd(6, 0, "R1 unused index");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=1 exp=0");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule